// File: doc/BRIEF.md
# SD Card Identification Sequencer

This block walks an SD card from power-up to the transfer state by steering a separate command engine. After a start pulse it idles the command line for a fixed number of SD clock periods. It then resets the card and probes the interface condition. Whether that probe is answered decides whether the card is treated as a first-generation part or a later one. The block polls the operating-condition application command until the card reports that power-up is complete, and reads the capacity flag from that response. An optional signalling-voltage switch follows. The block then reads the identification register, obtains the relative address, selects the card and programs the data bus width.

The command engine owns the line-level framing. This block presents an index and an argument with a one-cycle start pulse. It then waits for a completion pulse, which carries a no-response flag, a CRC flag and the 32-bit response argument. The clock divider stays on the slow identification rate until this block raises its fast-clock request. The outcome is reported as a done or error level with a 2-bit error code, together with the card-version flag, the capacity flag and the relative address.

Top module: `sd_init_seq`

## Requirements
- R1: After reset, every output is zero and no command is issued until `start` is pulsed.
- R2: After `start`, `preamble` stays high for exactly PRE_TICKS (default 74) cycles in which `sd_tick` is high, and no command is issued during that time. The first command issued afterwards is index 0 (card reset).
- R3: The interface-condition command uses index 8 and argument 0x000001AA. If it gets no response, the card is classed as first generation (`card_v2`=0) and the sequence continues. If it gets a correct response, `card_v2`=1.
- R4: If the index-8 response carries a CRC error, or if its bits [11:0] differ from 0x1AA, the sequence stops with `init_err`=1 and `err_code`=1, and no later command is issued.
- R5: Index 55 is issued before every index-41 and index-6 command. Its argument is {rca,16'h0}, where rca is zero until the relative address has been received.
- R6: The index-41 argument is 0x00FF8000, with bit 30 set when `card_v2`=1 and bit 24 set when both `use_v18` and `card_v2` are 1. The 55/41 pair is repeated while response bit 31 is 0. The CRC flag on an index-41 response is ignored.
- R7: If response bit 31 is still 0 on the attempt that brings the attempt count to `max_retries` (the first attempt when `max_retries`=0), the sequence stops with `err_code`=2.
- R8: `card_hc` takes bit 30 of the final index-41 response for a card with `card_v2`=1, and stays 0 for a first-generation card.
- R9: Index 11 is issued only when `use_v18`, `card_v2` and bit 24 of the final index-41 response are all 1. Index 2 follows, then index 3. `card_rca` takes bits [31:16] of the index-3 response.
- R10: Index 7 is issued with argument {rca,16'h0}. Index 6 follows with argument 2 when `wide_bus`=1 and 0 otherwise. When index 6 succeeds, `init_done`=1 and no further command is issued.
- R11: `fast_clk_req` rises only when index 6 completes without error, so it is never high without `init_done`.
- R12: A no-response or CRC flag on index 55, 11, 2, 3, 7 or 6 stops the sequence with `err_code`=3. The response flags of index 0 are ignored.
- R13: `cmd_start` is a one-cycle pulse, and no new command is issued while one is waiting for `cmd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin, or restart from done or error |
| sd_tick | input | 1 | One pulse per SD clock period |
| use_v18 | input | 1 | Request the low-voltage signalling switch |
| wide_bus | input | 1 | Select the 4-bit data bus (else 1-bit) |
| max_retries | input | RETRY_W | Operating-condition attempt limit |
| cmd_start | output | 1 | Issue command pulse to the engine |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Engine completion pulse |
| cmd_timeout | input | 1 | No response received, valid with cmd_done |
| cmd_crc_err | input | 1 | Response CRC failure, valid with cmd_done |
| rsp_arg | input | 32 | Response argument field, valid with cmd_done |
| preamble | output | 1 | Command line must idle high |
| fast_clk_req | output | 1 | Divider may leave identification rate |
| init_done | output | 1 | Card is in transfer state |
| init_err | output | 1 | Sequence aborted |
| err_code | output | 2 | 1 bad probe, 2 busy limit, 3 command failure |
| card_v2 | output | 1 | Card answered the interface probe |
| card_hc | output | 1 | High-capacity card |
| card_rca | output | 16 | Relative card address |

## Verification
The hardest cases to reach from the ports are the ones that depend on the card's answers rather than on any input of the block. These are the busy-polling limit hit on exactly the last allowed attempt, a voltage-switch grant that must be ignored for a first-generation card, and a failure injected at one specific point late in the sequence. The bench drives a behavioural card that answers each issued command after a short delay. Each table vector sets that card's probe behaviour, the number of busy replies it gives, its capacity and switch-grant bits, and the one command index it fails. The card model also checks every index-55 and index-41 argument as it arrives, and counts any overlapping issue.

// File: rtl/sd_init_seq.sv
module sd_init_seq #(
  parameter int PRE_TICKS = 74,
  parameter int RETRY_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sd_tick,
  input  logic               use_v18,
  input  logic               wide_bus,
  input  logic [RETRY_W-1:0] max_retries,
  output logic               cmd_start,
  output logic [5:0]         cmd_idx,
  output logic [31:0]        cmd_arg,
  input  logic               cmd_done,
  input  logic               cmd_timeout,
  input  logic               cmd_crc_err,
  input  logic [31:0]        rsp_arg,
  output logic               preamble,
  output logic               fast_clk_req,
  output logic               init_done,
  output logic               init_err,
  output logic [1:0]         err_code,
  output logic               card_v2,
  output logic               card_hc,
  output logic [15:0]        card_rca
);
  localparam int PRE_W = $clog2(PRE_TICKS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RST, S_PROBE, S_APP, S_OCR, S_VSW,
    S_CID, S_ADDR, S_SEL, S_BUSW, S_DONE, S_ERR
  } state_t;

  state_t             state;
  logic [PRE_W-1:0]   pre_cnt;
  logic [RETRY_W-1:0] tries;
  logic [RETRY_W:0]   tries_nx;
  logic               issued;
  logic               addr_phase;
  logic               rsp_bad;
  logic               unused_bits;

  assign tries_nx    = {1'b0, tries} + {{RETRY_W{1'b0}}, 1'b1};
  assign rsp_bad     = cmd_timeout | cmd_crc_err;
  assign unused_bits = ^rsp_arg[15:12];

  assign preamble  = (state == S_PRE);
  assign init_done = (state == S_DONE);
  assign init_err  = (state == S_ERR);
  assign cmd_start = !issued && state inside {S_RST, S_PROBE, S_APP, S_OCR,
                                              S_VSW, S_CID, S_ADDR, S_SEL, S_BUSW};

  always_comb begin
    cmd_idx = 6'd0;
    cmd_arg = 32'h0;
    case (state)
      S_PROBE: begin cmd_idx = 6'd8;  cmd_arg = 32'h0000_01AA; end
      S_APP:   begin cmd_idx = 6'd55; cmd_arg = {card_rca, 16'h0}; end
      S_OCR:   begin
        cmd_idx = 6'd41;
        cmd_arg = 32'h00FF_8000 | {1'b0, card_v2, 5'b0, use_v18 & card_v2, 24'h0};
      end
      S_VSW:   cmd_idx = 6'd11;
      S_CID:   cmd_idx = 6'd2;
      S_ADDR:  cmd_idx = 6'd3;
      S_SEL:   begin cmd_idx = 6'd7;  cmd_arg = {card_rca, 16'h0}; end
      S_BUSW:  begin cmd_idx = 6'd6;  cmd_arg = {30'h0, wide_bus, 1'b0}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      pre_cnt      <= '0;
      tries        <= '0;
      issued       <= 1'b0;
      addr_phase   <= 1'b0;
      fast_clk_req <= 1'b0;
      err_code     <= 2'd0;
      card_v2      <= 1'b0;
      card_hc      <= 1'b0;
      card_rca     <= 16'h0;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_ERR: begin
          if (start) begin
            state        <= S_PRE;
            pre_cnt      <= '0;
            tries        <= '0;
            issued       <= 1'b0;
            addr_phase   <= 1'b0;
            fast_clk_req <= 1'b0;
            err_code     <= 2'd0;
            card_v2      <= 1'b0;
            card_hc      <= 1'b0;
            card_rca     <= 16'h0;
          end
        end
        S_PRE: begin
          if (sd_tick) begin
            if (pre_cnt == PRE_W'(PRE_TICKS - 1)) state <= S_RST;
            else pre_cnt <= pre_cnt + 1'b1;
          end
        end
        default: begin
          if (!issued) begin
            issued <= 1'b1;
          end else if (cmd_done) begin
            issued <= 1'b0;
            case (state)
              S_RST: state <= S_PROBE;
              S_PROBE: begin
                if (cmd_timeout) state <= S_APP;
                else if (cmd_crc_err || rsp_arg[11:0] != 12'h1AA) begin
                  state <= S_ERR; err_code <= 2'd1;
                end else begin
                  card_v2 <= 1'b1; state <= S_APP;
                end
              end
              S_APP: begin
                if (rsp_bad) begin state <= S_ERR; err_code <= 2'd3; end
                else state <= addr_phase ? S_BUSW : S_OCR;
              end
              S_OCR: begin
                if (cmd_timeout) begin
                  state <= S_ERR; err_code <= 2'd3;
                end else if (!rsp_arg[31]) begin
                  if (tries_nx >= {1'b0, max_retries}) begin
                    state <= S_ERR; err_code <= 2'd2;
                  end else begin
                    tries <= tries_nx[RETRY_W-1:0]; state <= S_APP;
                  end
                end else begin
                  card_hc <= card_v2 & rsp_arg[30];
                  state   <= (use_v18 && card_v2 && rsp_arg[24]) ? S_VSW : S_CID;
                end
              end
              S_VSW: begin
                if (rsp_bad) begin state <= S_ERR; err_code <= 2'd3; end
                else state <= S_CID;
              end
              S_CID: begin
                if (rsp_bad) begin state <= S_ERR; err_code <= 2'd3; end
                else state <= S_ADDR;
              end
              S_ADDR: begin
                if (rsp_bad) begin state <= S_ERR; err_code <= 2'd3; end
                else begin card_rca <= rsp_arg[31:16]; state <= S_SEL; end
              end
              S_SEL: begin
                if (rsp_bad) begin state <= S_ERR; err_code <= 2'd3; end
                else begin addr_phase <= 1'b1; state <= S_APP; end
              end
              S_BUSW: begin
                if (rsp_bad) begin state <= S_ERR; err_code <= 2'd3; end
                else begin fast_clk_req <= 1'b1; state <= S_DONE; end
              end
              default: state <= S_IDLE;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sd_init_seq_chk.sv
module sd_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic        preamble,
  input logic        fast_clk_req,
  input logic        init_done,
  input logic        init_err,
  input logic        card_v2,
  input logic        card_hc,
  input logic [15:0] card_rca
);
  assert_fast_needs_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clk_req |-> init_done);
  assert_quiet_preamble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    preamble |-> !cmd_start);
  assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  assert_hc_implies_v2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    card_hc |-> card_v2);
  assert_silent_when_finished_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done || init_err) |-> !cmd_start);
  assert_exclusive_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_err));
  assert_rca_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |-> $stable(card_rca));
endmodule

bind sd_init_seq sd_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .preamble(preamble),
  .fast_clk_req(fast_clk_req), .init_done(init_done), .init_err(init_err),
  .card_v2(card_v2), .card_hc(card_hc), .card_rca(card_rca)
);

// File: tb/test_sd_init_seq.sv
module test_sd_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CARD_RCA = 16'hB37C;
  localparam int NVEC = 14;
  // {probe[2],busy[4],ccs,s18a,use18,wide,maxr[4],fail[6], done,code[2],v2,hc,n41[4],saw11}
  localparam logic [29:0] VEC [NVEC] = '{
    {2'd1,4'd2,1'b1,1'b0,1'b0,1'b1,4'd8,6'd63, 1'b1,2'd0,1'b1,1'b1,4'd3,1'b0},
    {2'd0,4'd1,1'b1,1'b1,1'b1,1'b0,4'd8,6'd63, 1'b1,2'd0,1'b0,1'b0,4'd2,1'b0},
    {2'd1,4'd0,1'b0,1'b1,1'b1,1'b1,4'd8,6'd63, 1'b1,2'd0,1'b1,1'b0,4'd1,1'b1},
    {2'd1,4'd0,1'b1,1'b1,1'b0,1'b1,4'd8,6'd63, 1'b1,2'd0,1'b1,1'b1,4'd1,1'b0},
    {2'd2,4'd0,1'b0,1'b0,1'b0,1'b1,4'd8,6'd63, 1'b0,2'd1,1'b0,1'b0,4'd0,1'b0},
    {2'd3,4'd0,1'b0,1'b0,1'b0,1'b1,4'd8,6'd63, 1'b0,2'd1,1'b0,1'b0,4'd0,1'b0},
    {2'd1,4'd5,1'b0,1'b0,1'b0,1'b1,4'd3,6'd63, 1'b0,2'd2,1'b1,1'b0,4'd3,1'b0},
    {2'd1,4'd2,1'b1,1'b0,1'b0,1'b0,4'd3,6'd63, 1'b1,2'd0,1'b1,1'b1,4'd3,1'b0},
    {2'd1,4'd0,1'b0,1'b0,1'b0,1'b1,4'd8,6'd3,  1'b0,2'd3,1'b1,1'b0,4'd1,1'b0},
    {2'd1,4'd0,1'b0,1'b0,1'b0,1'b1,4'd8,6'd55, 1'b0,2'd3,1'b1,1'b0,4'd0,1'b0},
    {2'd0,4'd0,1'b0,1'b0,1'b0,1'b1,4'd8,6'd7,  1'b0,2'd3,1'b0,1'b0,4'd1,1'b0},
    {2'd0,4'd0,1'b0,1'b0,1'b0,1'b1,4'd0,6'd63, 1'b1,2'd0,1'b0,1'b0,4'd1,1'b0},
    {2'd1,4'd1,1'b0,1'b0,1'b0,1'b1,4'd0,6'd63, 1'b0,2'd2,1'b1,1'b0,4'd1,1'b0},
    {2'd1,4'd0,1'b0,1'b1,1'b1,1'b0,4'd8,6'd11, 1'b0,2'd3,1'b1,1'b0,4'd1,1'b1}
  };

  logic clk = 0, rst_n = 0, start = 0, sd_tick = 0, use_v18 = 0, wide_bus = 0;
  logic [7:0] max_retries = 8'd8;
  logic cmd_start, cmd_done = 0, cmd_timeout = 0, cmd_crc_err = 0;
  logic [5:0] cmd_idx;
  logic [31:0] cmd_arg, rsp_arg = 0;
  logic preamble, fast_clk_req, init_done, init_err, card_v2, card_hc;
  logic [1:0] err_code;
  logic [15:0] card_rca;

  int checks = 0, errors = 0;
  logic [1:0] m_probe = 0; logic [3:0] m_busy = 0; logic m_ccs = 0, m_s18a = 0;
  logic [5:0] m_fail = 6'd63;
  int n_cmd, n41, n11, bad55, bad41, overlap, pre_ticks, first_idx, delay;
  logic pending, rca_given;
  logic [5:0] cur_idx; logic [31:0] cur_arg, arg6, arg7;

  sd_init_seq i_sd_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sd_tick(sd_tick),
    .use_v18(use_v18), .wide_bus(wide_bus), .max_retries(max_retries),
    .cmd_start(cmd_start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .cmd_done(cmd_done), .cmd_timeout(cmd_timeout), .cmd_crc_err(cmd_crc_err),
    .rsp_arg(rsp_arg), .preamble(preamble), .fast_clk_req(fast_clk_req),
    .init_done(init_done), .init_err(init_err), .err_code(err_code),
    .card_v2(card_v2), .card_hc(card_hc), .card_rca(card_rca)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic clear_log();
    n_cmd = 0; n41 = 0; n11 = 0; bad55 = 0; bad41 = 0; overlap = 0;
    pre_ticks = 0; first_idx = -1; pending = 0; rca_given = 0; delay = 0;
    arg6 = 32'hFFFF_FFFF; arg7 = 32'hFFFF_FFFF;
  endtask

  // Card model: answers each issued command three cycles later
  always @(negedge clk) begin
    cmd_done = 0; cmd_timeout = 0; cmd_crc_err = 0; rsp_arg = 0;
    sd_tick = ~sd_tick;
    if (preamble && sd_tick) pre_ticks++;
    if (cmd_start) begin
      if (pending) overlap++;
      if (n_cmd == 0) first_idx = cmd_idx;
      n_cmd++; pending = 1; delay = 3; cur_idx = cmd_idx; cur_arg = cmd_arg;
      if (cmd_idx == 6'd55 && cmd_arg != {rca_given ? CARD_RCA : 16'h0, 16'h0}) bad55++;
      if (cmd_idx == 6'd41 && cmd_arg != (32'h00FF_8000 | {1'b0, m_probe == 2'd1, 5'b0,
          use_v18 && m_probe == 2'd1, 24'h0})) bad41++;
      if (cmd_idx == 6'd41) n41++;
      if (cmd_idx == 6'd11) n11++;
      if (cmd_idx == 6'd6) arg6 = cmd_arg;
      if (cmd_idx == 6'd7) arg7 = cmd_arg;
    end else if (pending) begin
      delay--;
      if (delay == 0) begin
        pending = 0; cmd_done = 1;
        if (cur_idx == 6'd0) cmd_timeout = 1;
        else if (cur_idx == m_fail) cmd_timeout = 1;
        else case (cur_idx)
          6'd8: case (m_probe)
            2'd0: cmd_timeout = 1;
            2'd1: rsp_arg = 32'h0000_01AA;
            2'd2: rsp_arg = 32'h0000_01A5;
            default: begin rsp_arg = 32'h0000_01AA; cmd_crc_err = 1; end
          endcase
          6'd41: begin
            cmd_crc_err = 1;
            if (m_busy != 0) begin rsp_arg = 32'h00FF_8000; m_busy--; end
            else rsp_arg = {1'b1, m_ccs, 5'b0, m_s18a, 24'hFF_8000};
          end
          6'd3: begin rsp_arg = {CARD_RCA, 16'h0500}; rca_given = 1; end
          default: rsp_arg = 32'h0000_0900;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (20) @(negedge clk);
    // R1 reset state and no command without start
    check({cmd_start, preamble, fast_clk_req, init_done, init_err, err_code,
           card_v2, card_hc} == 0 && card_rca == 0, "R1 outputs", {init_done, init_err}, 0);
    check(n_cmd == 0, "R1 no command", n_cmd, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [29:0] v;
      v = VEC[i];
      rst_n = 0;
      m_probe = v[29:28]; m_busy = v[27:24]; m_ccs = v[23]; m_s18a = v[22];
      use_v18 = v[21]; wide_bus = v[20]; max_retries = {4'b0, v[19:16]}; m_fail = v[15:10];
      repeat (2) @(negedge clk);
      clear_log();
      rst_n = 1;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      for (int k = 0; k < 5000 && !(init_done || init_err); k++) @(negedge clk);
      repeat (6) @(negedge clk);
      check(pre_ticks == 74, "R2 preamble ticks", pre_ticks, 74);
      check(first_idx == 0, "R2 first command", first_idx, 0);
      check(init_done == v[9], "R10 done", init_done, v[9]);
      check(init_err == (v[8:7] != 0), "R12 error flag", init_err, v[8:7] != 0);
      check(err_code == v[8:7], v[8:7] == 1 ? "R4 code" : v[8:7] == 2 ? "R7 code" : "R12 code",
            err_code, v[8:7]);
      check(card_v2 == v[6], "R3 version", card_v2, v[6]);
      check(card_hc == v[5], "R8 capacity", card_hc, v[5]);
      check(n41 == v[4:1], "R6 attempts", n41, v[4:1]);
      check(n11 == v[0], "R9 voltage switch", n11, v[0]);
      check(bad55 == 0, "R5 prefix argument", bad55, 0);
      check(bad41 == 0, "R6 argument", bad41, 0);
      check(overlap == 0, "R13 overlap", overlap, 0);
      check(fast_clk_req == v[9], "R11 fast clock", fast_clk_req, v[9]);
      if (v[9]) begin
        check(card_rca == CARD_RCA, "R9 address", card_rca, CARD_RCA);
        check(arg7 == {CARD_RCA, 16'h0}, "R10 select argument", arg7, {CARD_RCA, 16'h0});
        check(arg6 == {30'h0, wide_bus, 1'b0}, "R10 width argument", arg6, {wide_bus, 1'b0});
      end
      if (v[8:7] == 1) check(n_cmd == 2, "R4 stops", n_cmd, 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule